// File: doc/BRIEF.md
# Payload Cell Extractor for a 48-Channel Concatenated Frame

The block sits on the receive side of a backplane link. It takes an already aligned byte stream of a 9-row concatenated frame together with a column marker and a frame-start marker. It skips the overhead columns and recovers fixed-size cells from their position inside the payload area alone. Every frame restarts the cell grid at the first payload byte.

Each cell on the line is built from three parts: a one-byte link header, the user payload, and a trailing parity byte. The extractor checks the header and the parity and removes both. It drops idle cells and the pad bytes left at the end of the payload area. The user payload goes out one byte per cycle, with start-of-cell and end-of-cell markers. An error flag is raised together with end-of-cell when the header is invalid, when the parity check fails, or when a new frame cuts a cell short.

The cell size is chosen by a 2-bit input and is expected to stay constant while traffic runs.

Top module: `cx_cell_extract`

## Requirements
- R1: Bytes at columns 1 to 144 (`in_col`, 1-based) are overhead and never reach the output. Payload begins at column 145.
- R2: The first cell of a frame begins at the first payload byte after the frame start, which is row 1, column 145. Later cells follow back to back across row boundaries.
- R3: `size_sel` selects the line cell length: 0 gives 77, 1 gives 81, 2 gives 85, 3 gives 93 bytes. A cell is laid out as byte 0 = link header, then length-2 payload bytes, then the last byte = parity. Each delivered cell gives exactly length-2 output bytes, with `out_sop` on the first and `out_eop` on the last.
- R4: A frame carries 488, 464, 442 or 404 cells for `size_sel` 0 to 3. The payload bytes that remain after the last whole cell are discarded: 8, 0, 14 and 12 bytes respectively.
- R5: A header of 8'hC3 marks a data cell. A header of 8'h3C marks an idle cell, which is dropped with no output. Any other header value delivers the cell with `out_err` set on its end-of-cell byte.
- R6: The parity byte must equal the XOR of the cell's payload bytes. On a mismatch, `out_err` is set together with `out_eop`. `out_err` is never set on any other byte.
- R7: `in_fs` (qualified by `in_valid`, given on row 1 column 1) restarts the cell grid. If a data cell is still open at that moment, its remaining held byte is delivered with `out_eop` and `out_err` set.
- R8: After reset, no payload is processed until the first frame start.
- R9: During reset `out_valid` is low. A reset discards any partly delivered cell, and nothing more of that cell is delivered.
- R10: Cycles with `in_valid` low are ignored and do not move the position. `out_valid` is only raised in the cycle after an accepted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| size_sel | input | 2 | Cell length select (R3 encoding) |
| in_valid | input | 1 | Input byte qualifier |
| in_fs | input | 1 | First byte of a frame |
| in_col | input | COL_W | Column of the input byte, 1-based |
| in_data | input | 8 | Frame byte |
| out_valid | output | 1 | Output byte qualifier |
| out_data | output | 8 | User payload byte |
| out_sop | output | 1 | First payload byte of a cell |
| out_eop | output | 1 | Last payload byte of a cell |
| out_err | output | 1 | Cell error, only with `out_eop` |

## Verification
The hardest situations to reach are the two ends of a frame. One is the pad region after the last whole cell. The other is a new frame start that lands while a cell is open and one byte is still held back. Both sit tens of thousands of bytes into a frame. The bench therefore drives complete frames for every cell size, with a real header byte placed at the start of the pad to tempt false delineation. It then cuts a frame short in the middle of a cell, with input gaps interleaved, and follows it with a new frame start, so that the truncation close-out and the realignment are seen at the ports.

// File: rtl/cx_pkg.sv
package cx_pkg;

  typedef enum logic [1:0] {
    BK_NONE,
    BK_HDR,
    BK_PAY,
    BK_PAR
  } byte_kind_e;

  localparam int LEN_W = 7;

  // line length of one cell for each size code
  function automatic logic [LEN_W-1:0] cell_len(input logic [1:0] sel);
    logic [LEN_W-1:0] r;
    case (sel)
      2'd0:    r = 7'd77;
      2'd1:    r = 7'd81;
      2'd2:    r = 7'd85;
      default: r = 7'd93;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cx_rst_sync.sv
module cx_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= 2'b00;
    else         sh_q <= {sh_q[0], 1'b1};
  end

  assign srst_n = sh_q[1];

endmodule

// File: rtl/cx_pos_track.sv
module cx_pos_track import cx_pkg::*; #(
  parameter int NUM_COLS = 4320,
  parameter int OH_COLS  = 144,
  parameter int NUM_ROWS = 9,
  parameter int COL_W    = 13,
  parameter int CI_W     = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_fs,
  input  logic [COL_W-1:0] in_col,
  input  logic [1:0]       size_sel,
  output byte_kind_e       kind,
  output logic             first_pay,
  output logic             fs_evt,
  output logic             synced,
  output logic             in_pad,
  output logic [LEN_W-1:0] byte_pos,
  output logic [CI_W-1:0]  cell_idx
);

  localparam int PAY_BYTES = NUM_ROWS * (NUM_COLS - OH_COLS);

  logic [CI_W-1:0]  nc_tab [4];
  logic [LEN_W-1:0] len;
  logic [LEN_W-1:0] pos_q, pos_eff, pos_n;
  logic [CI_W-1:0]  idx_q, idx_eff, idx_n;
  logic             sync_q, sync_n;
  logic             is_pay;

  // whole cells per frame for each size code, fixed at elaboration
  for (genvar g = 0; g < 4; g++) begin : g_ncells
    assign nc_tab[g] = CI_W'(PAY_BYTES / int'(cell_len(2'(g))));
  end

  assign len     = cell_len(size_sel);
  assign fs_evt  = in_valid & in_fs;
  assign pos_eff = fs_evt ? '0 : pos_q;
  assign idx_eff = fs_evt ? '0 : idx_q;
  assign is_pay  = in_valid & (sync_q | fs_evt) & (in_col > COL_W'(OH_COLS));
  assign in_pad  = idx_eff >= nc_tab[size_sel];

  always_comb begin
    if (!is_pay || in_pad)              kind = BK_NONE;
    else if (pos_eff == '0)             kind = BK_HDR;
    else if (pos_eff == len - 7'd1)     kind = BK_PAR;
    else                                kind = BK_PAY;
  end

  always_comb begin
    pos_n  = pos_eff;
    idx_n  = idx_eff;
    sync_n = sync_q | fs_evt;
    if (kind == BK_PAR) begin
      pos_n = '0;
      idx_n = idx_eff + CI_W'(1);
    end else if (kind != BK_NONE) begin
      pos_n = pos_eff + 7'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      idx_q  <= '0;
      sync_q <= 1'b0;
    end else if (in_valid) begin
      pos_q  <= pos_n;
      idx_q  <= idx_n;
      sync_q <= sync_n;
    end
  end

  assign first_pay = (pos_eff == 7'd1);
  assign synced    = sync_q;
  assign byte_pos  = pos_q;
  assign cell_idx  = idx_q;

endmodule

// File: rtl/cx_cell_check.sv
module cx_cell_check import cx_pkg::*; #(
  parameter logic [7:0] HDR_DATA = 8'hC3,
  parameter logic [7:0] HDR_IDLE = 8'h3C
) (
  input  logic       clk,
  input  logic       rst_n,
  input  byte_kind_e kind,
  input  logic [7:0] data,
  output logic       idle,
  output logic       par_err
);

  logic       hdr_ok_q, hdr_ok_n;
  logic       idle_q, idle_n;
  logic [7:0] bip_q, bip_n;
  logic       en;

  assign en = (kind == BK_HDR) || (kind == BK_PAY);

  always_comb begin
    hdr_ok_n = hdr_ok_q;
    idle_n   = idle_q;
    bip_n    = bip_q;
    if (kind == BK_HDR) begin
      hdr_ok_n = (data == HDR_DATA);
      idle_n   = (data == HDR_IDLE);
      bip_n    = '0;
    end else begin
      bip_n    = bip_q ^ data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_ok_q <= 1'b0;
      idle_q   <= 1'b0;
      bip_q    <= '0;
    end else if (en) begin
      hdr_ok_q <= hdr_ok_n;
      idle_q   <= idle_n;
      bip_q    <= bip_n;
    end
  end

  assign idle    = idle_q;
  assign par_err = !hdr_ok_q || (bip_q != data);

endmodule

// File: rtl/cx_out_stage.sv
module cx_out_stage import cx_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  byte_kind_e kind,
  input  logic [7:0] data,
  input  logic       first_pay,
  input  logic       idle,
  input  logic       par_err,
  input  logic       fs_evt,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_sop,
  output logic       out_eop,
  output logic       out_err
);

  logic       hv_q, hv_n;
  logic [7:0] hd_q, hd_n;
  logic       hf_q, hf_n;
  logic       ov_n, os_n, oe_n, oerr_n;
  logic [7:0] od_n;

  always_comb begin
    hv_n   = hv_q;
    hd_n   = hd_q;
    hf_n   = hf_q;
    ov_n   = 1'b0;
    od_n   = out_data;
    os_n   = 1'b0;
    oe_n   = 1'b0;
    oerr_n = 1'b0;
    if (fs_evt && hv_q) begin
      // frame restart cuts the open cell: close it as errored
      ov_n   = 1'b1;
      od_n   = hd_q;
      os_n   = hf_q;
      oe_n   = 1'b1;
      oerr_n = 1'b1;
      hv_n   = 1'b0;
    end else if (kind == BK_PAY && !idle) begin
      if (hv_q) begin
        ov_n = 1'b1;
        od_n = hd_q;
        os_n = hf_q;
      end
      hd_n = data;
      hf_n = first_pay;
      hv_n = 1'b1;
    end else if (kind == BK_PAR && !idle && hv_q) begin
      ov_n   = 1'b1;
      od_n   = hd_q;
      os_n   = hf_q;
      oe_n   = 1'b1;
      oerr_n = par_err;
      hv_n   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hv_q      <= 1'b0;
      hd_q      <= '0;
      hf_q      <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      out_err   <= 1'b0;
    end else begin
      hv_q      <= hv_n;
      hd_q      <= hd_n;
      hf_q      <= hf_n;
      out_valid <= ov_n;
      out_data  <= od_n;
      out_sop   <= os_n;
      out_eop   <= oe_n;
      out_err   <= oerr_n;
    end
  end

endmodule

// File: rtl/cx_cell_extract.sv
module cx_cell_extract import cx_pkg::*; #(
  parameter int         NUM_COLS = 4320,
  parameter int         OH_COLS  = 144,
  parameter int         NUM_ROWS = 9,
  parameter int         COL_W    = 13,
  parameter logic [7:0] HDR_DATA = 8'hC3,
  parameter logic [7:0] HDR_IDLE = 8'h3C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       size_sel,
  input  logic             in_valid,
  input  logic             in_fs,
  input  logic [COL_W-1:0] in_col,
  input  logic [7:0]       in_data,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_sop,
  output logic             out_eop,
  output logic             out_err
);

  localparam int PAY_BYTES = NUM_ROWS * (NUM_COLS - OH_COLS);
  localparam int CI_W      = $clog2(PAY_BYTES / 77 + 2);

  logic             rst_s_n;
  byte_kind_e       kind;
  logic             first_pay, fs_evt, synced, in_pad;
  logic [LEN_W-1:0] byte_pos;
  logic [CI_W-1:0]  cell_idx;
  logic             idle, par_err;

  cx_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_s_n)
  );

  cx_pos_track #(
    .NUM_COLS (NUM_COLS),
    .OH_COLS  (OH_COLS),
    .NUM_ROWS (NUM_ROWS),
    .COL_W    (COL_W),
    .CI_W     (CI_W)
  ) u_pos (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .in_valid  (in_valid),
    .in_fs     (in_fs),
    .in_col    (in_col),
    .size_sel  (size_sel),
    .kind      (kind),
    .first_pay (first_pay),
    .fs_evt    (fs_evt),
    .synced    (synced),
    .in_pad    (in_pad),
    .byte_pos  (byte_pos),
    .cell_idx  (cell_idx)
  );

  cx_cell_check #(
    .HDR_DATA (HDR_DATA),
    .HDR_IDLE (HDR_IDLE)
  ) u_chk_cell (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .kind    (kind),
    .data    (in_data),
    .idle    (idle),
    .par_err (par_err)
  );

  cx_out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .kind      (kind),
    .data      (in_data),
    .first_pay (first_pay),
    .idle      (idle),
    .par_err   (par_err),
    .fs_evt    (fs_evt),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_sop   (out_sop),
    .out_eop   (out_eop),
    .out_err   (out_err)
  );

endmodule

// File: rtl/cx_extract_chk.sv
module cx_extract_chk #(
  parameter int OH_COLS = 144,
  parameter int COL_W   = 13,
  parameter int POS_W   = 7,
  parameter int CI_W    = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_fs,
  input logic [COL_W-1:0] in_col,
  input logic             out_valid,
  input logic             out_sop,
  input logic             out_eop,
  input logic             out_err,
  input logic             synced,
  input logic             in_pad,
  input logic [POS_W-1:0] byte_pos,
  input logic [CI_W-1:0]  cell_idx
);

  logic open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         open_q <= 1'b0;
    else if (out_valid) open_q <= !out_eop;
  end

  // R1: an overhead byte that is not a frame start never leads to output
  p_oh_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_fs && (in_col <= COL_W'(OH_COLS)) |=> !out_valid);

  // R3: a start-of-cell byte only when no cell is open
  p_sop_closed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sop |-> !open_q);

  // R3: continuation and end bytes only inside an open cell
  p_mid_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_sop |-> open_q);

  // R4: pad bytes produce nothing
  p_pad_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_fs && in_pad |=> !out_valid);

  // R6: the error flag only travels with end-of-cell
  p_err_eop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> out_valid && out_eop);

  // R7: a frame start on an overhead byte clears the position
  p_fs_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_fs && (in_col <= COL_W'(OH_COLS)) |=> (byte_pos == '0) && (cell_idx == '0));

  // R8: nothing leaves before the first frame start
  p_unsynced_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !synced && !(in_valid && in_fs) |=> !out_valid);

  // R10: idle input cycles produce no output
  p_gap_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

endmodule

bind cx_cell_extract cx_extract_chk #(
  .OH_COLS (OH_COLS),
  .COL_W   (COL_W),
  .POS_W   (cx_pkg::LEN_W),
  .CI_W    (CI_W)
) u_extract_chk (
  .clk       (clk),
  .rst_n     (rst_s_n),
  .in_valid  (in_valid),
  .in_fs     (in_fs),
  .in_col    (in_col),
  .out_valid (out_valid),
  .out_sop   (out_sop),
  .out_eop   (out_eop),
  .out_err   (out_err),
  .synced    (synced),
  .in_pad    (in_pad),
  .byte_pos  (byte_pos),
  .cell_idx  (cell_idx)
);

// File: tb/test_cx_cell_extract.sv
`timescale 1ns/1ps
module test_cx_cell_extract;

  localparam int COLS   = 4320;
  localparam int OH     = 144;
  localparam int PAYROW = COLS - OH;
  localparam int COL_W  = 13;

  // sel, idle_mod, badhdr_mod, badpar_mod, cells per frame (R4)
  localparam int VEC [4][5] = '{
    '{0, 5, 0,  0, 488},
    '{1, 0, 7,  0, 464},
    '{2, 0, 0,  6, 442},
    '{3, 9, 11, 4, 404}
  };

  logic             clk, rst_n;
  logic [1:0]       size_sel;
  logic             in_valid, in_fs;
  logic [COL_W-1:0] in_col;
  logic [7:0]       in_data;
  logic             out_valid, out_sop, out_eop, out_err;
  logic [7:0]       out_data;

  typedef struct {
    logic [7:0] d;
    logic       sop;
    logic       eop;
    logic       err;
    int         tag;
  } exp_t;

  exp_t exp_q[$];
  int   tests, fails, cyc;
  int   out_cnt, got_eop, got_err, exp_eop, exp_err;
  bit   open_cell, mon_en;
  string cur_req;

  cx_cell_extract i_cx_cell_extract (
    .clk(clk), .rst_n(rst_n), .size_sel(size_sel), .in_valid(in_valid),
    .in_fs(in_fs), .in_col(in_col), .in_data(in_data), .out_valid(out_valid),
    .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop), .out_err(out_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic string tag_name(input int t);
    case (t)
      5:       return "R5";
      6:       return "R6";
      7:       return "R7";
      default: return "R3";
    endcase
  endfunction

  function automatic int tb_len(input int sel);  // R3 encoding
    case (sel)
      0:       return 77;
      1:       return 81;
      2:       return 85;
      default: return 93;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      tests++; fails++;
      $display("FAIL R10 watchdog: actual %0d cycles expected below %0d", cyc, 190000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // output monitor, away from the active edge
  always @(negedge clk) begin
    if (mon_en && rst_n && out_valid) begin
      out_cnt++;
      if (out_eop) got_eop++;
      if (out_err) got_err++;
      if (exp_q.size() == 0) begin
        chk(1'b0, cur_req, "unexpected output byte", int'(out_data), -1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        // R2/R3: byte order, contiguity and markers
        chk(out_data == e.d && out_sop == e.sop && out_eop == e.eop, "R2/R3", "byte/sop/eop",
            int'({out_sop, out_eop, out_data}), int'({e.sop, e.eop, e.d}));
        chk(out_err == e.err, tag_name(e.tag), "error flag", int'(out_err), int'(e.err));
      end
    end
  end

  task automatic push(input logic [7:0] d, input bit sop, input bit eop, input bit err, input int tag);
    exp_t e;
    e.d = d; e.sop = sop; e.eop = eop; e.err = err; e.tag = tag;
    exp_q.push_back(e);
    if (eop) begin
      exp_eop++;
      if (err) exp_err++;
    end
    open_cell = !eop;
  endtask

  task automatic drive_frame(input int sel, input int idle_mod, input int hdr_mod,
                             input int bip_mod, input int ncells, input int limit,
                             input int gap_mod);
    int len;
    logic [7:0] x;
    len = tb_len(sel);
    x = '0;
    if (open_cell) begin  // R7: the held byte of the cut cell closes with error
      exp_q[exp_q.size()-1].eop = 1'b1;
      exp_q[exp_q.size()-1].err = 1'b1;
      exp_q[exp_q.size()-1].tag = 7;
      exp_eop++; exp_err++;
      open_cell = 1'b0;
    end
    for (int k = 0; k < limit; k++) begin
      int col;
      int row;
      logic [7:0] d;
      col = k % COLS + 1;
      row = k / COLS;
      if (gap_mod != 0 && k % gap_mod == 1) begin  // R10: junk while invalid
        @(negedge clk);
        in_valid = 1'b0; in_fs = 1'b1; in_col = 13'd300; in_data = 8'hC3;
      end
      if (col <= OH) begin
        d = (col % 2 == 1) ? 8'hC3 : 8'h3C;  // R1: header-like overhead
      end else begin
        int p;
        int c;
        int b;
        p = row * PAYROW + col - OH - 1;
        c = p / len;
        b = p % len;
        if (c >= ncells) begin
          d = (p == ncells * len) ? 8'hC3 : 8'(p);  // R4 pad
        end else begin
          bit idl;
          bit bh;
          bit bb;
          idl = idle_mod != 0 && c % idle_mod == 1;
          bh  = !idl && hdr_mod != 0 && c % hdr_mod == 2;
          bb  = bip_mod != 0 && c % bip_mod == 3;
          if (b == 0) begin
            d = idl ? 8'h3C : (bh ? 8'h81 : 8'hC3);
            x = '0;
          end else if (b == len - 1) begin
            d = x ^ (bb ? 8'h40 : 8'h00);
          end else begin
            d = 8'(c * 7 + b * 13 + sel * 3 + 1);
            x = x ^ d;
            if (!idl)
              push(d, b == 1, b == len - 2, (bh || bb) && b == len - 2,
                   (b == len - 2) ? (bb ? 6 : (bh ? 5 : 3)) : 3);
          end
        end
      end
      @(negedge clk);
      in_valid = 1'b1; in_fs = (k == 0); in_col = COL_W'(col); in_data = d;
      size_sel = 2'(sel);
    end
    @(negedge clk);
    in_valid = 1'b0; in_fs = 1'b0;
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int e0;
    int r0;
    int o0;
    tests = 0; fails = 0; cyc = 0; out_cnt = 0;
    got_eop = 0; got_err = 0; exp_eop = 0; exp_err = 0;
    open_cell = 1'b0; mon_en = 1'b0; cur_req = "R8";
    rst_n = 1'b0; size_sel = 2'd0; in_valid = 1'b0; in_fs = 1'b0;
    in_col = '0; in_data = '0;
    settle(4);
    chk(out_valid == 1'b0, "R9", "out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    mon_en = 1'b1;
    settle(4);
    chk(out_valid == 1'b0, "R9", "out_valid after reset", int'(out_valid), 0);

    // R8: payload-looking bytes before any frame start
    o0 = out_cnt;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_fs = 1'b0; in_col = COL_W'(OH + 1 + k);
      in_data = (k % 77 == 0) ? 8'hC3 : 8'(k);
    end
    @(negedge clk); in_valid = 1'b0;
    settle(3);
    chk(out_cnt == o0, "R8", "bytes out before sync", out_cnt - o0, 0);

    // table of full frames: R1..R6
    for (int v = 0; v < 4; v++) begin
      int idles;
      cur_req = "R4";
      idles = 0;
      for (int c = 0; c < VEC[v][4]; c++)
        if (VEC[v][1] != 0 && c % VEC[v][1] == 1) idles++;
      e0 = got_eop; r0 = got_err;
      begin
        int xe0;
        int xr0;
        xe0 = exp_eop; xr0 = exp_err;
        drive_frame(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], COLS * 9, 0);
        settle(3);
        chk(exp_q.size() == 0, "R3", "missing bytes at frame end", exp_q.size(), 0);
        chk(got_eop - e0 == VEC[v][4] - idles, "R4", "cells per frame", got_eop - e0, VEC[v][4] - idles);
        chk(got_err - r0 == exp_err - xr0, "R5/R6", "errored cells", got_err - r0, exp_err - xr0);
        chk(exp_eop - xe0 == VEC[v][4] - idles, "R5", "idle cells dropped", exp_eop - xe0, VEC[v][4] - idles);
      end
    end

    // R7 and R10: cut frame with input gaps, then a new frame start
    cur_req = "R7";
    drive_frame(0, 0, 0, 0, 488, OH + 100, 3);
    settle(3);
    chk(exp_q.size() == 1, "R7", "bytes pending before cut", exp_q.size(), 1);
    r0 = got_err;
    drive_frame(0, 0, 0, 0, 488, OH + 77 + 30, 0);
    settle(3);
    chk(got_err - r0 == 1, "R7", "truncation errors", got_err - r0, 1);
    chk(exp_q.size() == 1, "R10", "bytes pending in second frame", exp_q.size(), 1);

    // R9: reset with a cell open drops it
    cur_req = "R9";
    o0 = out_cnt;
    rst_n = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R9", "out_valid during reset", int'(out_valid), 0);
    exp_q.delete();
    open_cell = 1'b0;
    settle(2);
    rst_n = 1'b1;
    settle(10);
    chk(out_cnt == o0, "R9", "bytes after reset", out_cnt - o0, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule